// File: doc/BRIEF.md
# Retriggerable Digital One-Shot

This block is a clocked monostable. An accepted trigger loads a counter with a pulse length given in clock cycles. The output `q` stays high until that count runs out. `qN` always carries the inverse of `q`.

Two asynchronous trigger inputs can start a pulse:
- `trigPos` fires on its rising edge, but only while `trigNeg` is low.
- `trigNeg` fires on its falling edge, but only while `trigPos` is high.

Both inputs pass through a synchronizer and then a glitch filter. The filter passes only excursions that last at least `MIN_WIDTH` cycles.

Once a trigger is accepted, further triggers are ignored for `BLACKOUT` cycles. After that window, a new trigger restarts the count, so the pulse stretches to a full length measured from the latest accepted trigger.

The active-low `clearN` is sampled on the clock. It overrides everything: it ends any pulse and holds the output low while it stays low.

Top module: `retrig_oneshot`

## Requirements
- R1: A rising edge on `trigPos` while the filtered `trigNeg` is low and `clearN` is high starts a pulse. `q` (active high) rises on the clock edge SYNC_STAGES+MIN_WIDTH+1 cycles after the input changes.
- R2: A falling edge on `trigNeg` while the filtered `trigPos` is high starts a pulse with the same latency as R1.
- R3: A rising edge on `trigPos` while `trigNeg` is high is ignored. A falling edge on `trigNeg` while `trigPos` is low is ignored.
- R4: An excursion of a trigger input, high or low, that lasts fewer than MIN_WIDTH cycles is ignored. An excursion of exactly MIN_WIDTH cycles is accepted.
- R5: `q` stays high for exactly `pulseLen` cycles. `pulseLen` is captured when the trigger is accepted, so changing it later has no effect on the running pulse. A `pulseLen` of 0 gives no pulse.
- R6: A trigger accepted while a pulse is running reloads the count. `q` then stays high until `pulseLen` cycles after the new trigger.
- R7: A trigger whose edge comes BLACKOUT or fewer cycles after the previously accepted trigger is ignored. One arriving BLACKOUT+1 cycles later is accepted.
- R8: `clearN` low forces `q` low on the next clock edge. `q` stays low whatever the triggers do while `clearN` is low. An interrupted pulse does not resume after release.
- R9: A trigger edge detected in the first cycle in which `clearN` is high again is ignored. An edge detected one cycle later is accepted.
- R10: `qN` is the inverse of `q` in every cycle. After reset, `q` is 0 and `qN` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trigPos | input | 1 | Rising-edge trigger, asynchronous |
| trigNeg | input | 1 | Falling-edge trigger, asynchronous |
| clearN | input | 1 | Synchronous active-low overriding clear |
| pulseLen | input | CNT_W | Pulse length in cycles, captured on trigger |
| q | output | 1 | Pulse output |
| qN | output | 1 | Complement of q |

## Verification
The bench builds the block with CNT_W=8, MIN_WIDTH=3 and BLACKOUT=10.

A 3-cycle minimum makes a 2-cycle glitch representable and leaves the 3-cycle boundary exact. One input can re-fire no sooner than 6 cycles after its previous rising edge. A 10-cycle blackout is longer than that, so the window edge at 10 versus 11 cycles can be reached with `trigPos` alone.

An 8-bit count keeps stretched pulses short enough to measure edge by edge against an expected latency of 6 cycles.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  // Strobes from control to datapath; clear has priority over load.
  typedef struct packed {
    logic load;
    logic clear;
  } oneshotStrobe_t;
endpackage

// File: rtl/oneshot_edge_filter.sv
module oneshot_edge_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_WIDTH   = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic level,
  output logic changeStb
);
  localparam int RUN_W = (MIN_WIDTH > 1) ? $clog2(MIN_WIDTH + 1) : 1;
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(MIN_WIDTH - 1);

  logic [SYNC_STAGES-1:0] syncChain;
  logic [RUN_W-1:0]       runCnt;
  logic                   synced;

  assign synced = syncChain[SYNC_STAGES-1];

  // The filtered level follows the synchronized input only after it has
  // disagreed for MIN_WIDTH consecutive samples.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= '0;
      runCnt    <= '0;
      level     <= 1'b0;
      changeStb <= 1'b0;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], rawIn};
      changeStb <= 1'b0;
      if (synced == level) begin
        runCnt <= '0;
      end else if (runCnt == RUN_LAST) begin
        level     <= synced;
        runCnt    <= '0;
        changeStb <= 1'b1;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end

  // R4: the filtered level never moves without a change strobe
  assert_level_moves_with_strobe_R4: assert property (
    @(posedge clk) disable iff (!rstN) !$stable(level) |-> changeStb);
endmodule

// File: rtl/oneshot_ctrl.sv
module oneshot_ctrl
  import oneshot_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_WIDTH   = 3,
  parameter int BLACKOUT    = 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           trigPos,
  input  logic           trigNeg,
  input  logic           clearN,
  output oneshotStrobe_t strb
);
  localparam int BO_W = (BLACKOUT > 0) ? $clog2(BLACKOUT + 1) : 1;
  localparam logic [BO_W-1:0] BO_LOAD = BO_W'(BLACKOUT);

  logic [1:0]      rawIn;
  logic [1:0]      lvl;
  logic [1:0]      chg;
  logic            clrPrev;
  logic [BO_W-1:0] boCnt;
  logic            posFire;
  logic            negFire;
  logic            accept;

  assign rawIn = {trigNeg, trigPos};

  for (genvar i = 0; i < 2; i++) begin : g_in
    oneshot_edge_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .MIN_WIDTH  (MIN_WIDTH)
    ) u_filt (
      .clk      (clk),
      .rstN     (rstN),
      .rawIn    (rawIn[i]),
      .level    (lvl[i]),
      .changeStb(chg[i])
    );
  end

  // Index 0 = positive trigger, index 1 = negative trigger.
  assign posFire = chg[0] &  lvl[0] & ~lvl[1];
  assign negFire = chg[1] & ~lvl[1] &  lvl[0];
  assign accept  = (posFire | negFire) & clearN & clrPrev & (boCnt == '0);

  assign strb.load  = accept;
  assign strb.clear = ~clearN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clrPrev <= 1'b0;
      boCnt   <= '0;
    end else begin
      clrPrev <= clearN;
      if (!clearN)             boCnt <= '0;
      else if (accept)         boCnt <= BO_LOAD;
      else if (boCnt != '0)    boCnt <= boCnt - 1'b1;
    end
  end

  // R9: no load in the cycle clear is released
  assert_no_load_on_release_R9: assert property (
    @(posedge clk) disable iff (!rstN) $rose(clearN) |-> !strb.load);

  if (BLACKOUT > 0) begin : g_bo_chk
    // R7: accepted triggers are never back to back inside the window
    assert_blackout_spacing_R7: assert property (
      @(posedge clk) disable iff (!rstN) strb.load |=> !strb.load);
  end
endmodule

// File: rtl/oneshot_dp.sv
module oneshot_dp
  import oneshot_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  oneshotStrobe_t   strb,
  input  logic [CNT_W-1:0] pulseLen,
  output logic             q,
  output logic             qN
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] nextCnt;

  always_comb begin
    nextCnt = cnt;
    if (strb.clear)       nextCnt = '0;
    else if (strb.load)   nextCnt = pulseLen;
    else if (cnt != '0)   nextCnt = cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
      q   <= 1'b0;
      qN  <= 1'b1;
    end else begin
      cnt <= nextCnt;
      q   <= (nextCnt != '0);
      qN  <= (nextCnt == '0);
    end
  end

  // R8: clear drops the output at the next edge
  assert_clear_drops_q_R8: assert property (
    @(posedge clk) disable iff (!rstN) strb.clear |=> !q);

  // R6: a load (re)starts the full count
  assert_load_restarts_R6: assert property (
    @(posedge clk) disable iff (!rstN)
      (strb.load && !strb.clear && pulseLen != '0) |=> (q && cnt == $past(pulseLen)));

  // R5: output ends only on clear or on the last counted cycle
  assert_fall_on_expiry_R5: assert property (
    @(posedge clk) disable iff (!rstN)
      $fell(q) |-> ($past(strb.clear) || ($past(cnt) == CNT_W'(1) && !$past(strb.load))));
endmodule

// File: rtl/retrig_oneshot.sv
module retrig_oneshot
  import oneshot_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_WIDTH   = 3,
  parameter int BLACKOUT    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trigPos,
  input  logic             trigNeg,
  input  logic             clearN,
  input  logic [CNT_W-1:0] pulseLen,
  output logic             q,
  output logic             qN
);
  oneshotStrobe_t strb;

  oneshot_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .MIN_WIDTH  (MIN_WIDTH),
    .BLACKOUT   (BLACKOUT)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .trigPos(trigPos),
    .trigNeg(trigNeg),
    .clearN (clearN),
    .strb   (strb)
  );

  oneshot_dp #(
    .CNT_W(CNT_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .pulseLen(pulseLen),
    .q       (q),
    .qN      (qN)
  );
endmodule

// File: tb/retrig_oneshot_bench.sv
module retrig_oneshot_bench;
  localparam int CW  = 8;
  localparam int SS  = 2;
  localparam int MW  = 3;
  localparam int BO  = 10;
  localparam int LAT = SS + MW + 1;
  localparam int HMAX = 8192;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          trigPos = 1'b0;
  logic          trigNeg = 1'b0;
  logic          clearN = 1'b1;
  logic [CW-1:0] pulseLen = 8'd5;
  logic          q;
  logic          qN;

  int vectors = 0;
  int miscompares = 0;
  int edgeCnt = 0;
  int compBad = 0;
  bit qHist [0:HMAX-1];

  always #4 clk = ~clk;

  retrig_oneshot #(
    .CNT_W(CW), .SYNC_STAGES(SS), .MIN_WIDTH(MW), .BLACKOUT(BO)
  ) u_retrig_oneshot (
    .clk(clk), .rstN(rstN), .trigPos(trigPos), .trigNeg(trigNeg),
    .clearN(clearN), .pulseLen(pulseLen), .q(q), .qN(qN)
  );

  // Record q after every edge; qHist[k] holds the value registered at edge k.
  always @(posedge clk) begin
    int e;
    edgeCnt++;
    e = edgeCnt;
    #2;
    if (e < HMAX) qHist[e] = (q === 1'b1);
    if (qN !== ~q) compBad++;
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int riseAt(int from, int span);
    for (int i = from; i < from + span && i < HMAX; i++)
      if (qHist[i]) return i;
    return -1;
  endfunction

  function automatic int widthAt(int idx);
    int w = 0;
    if (idx < 0) return 0;
    for (int i = idx; i < HMAX && qHist[i]; i++) w++;
    return w;
  endfunction

  function automatic int onesIn(int from, int span);
    int n = 0;
    for (int i = from; i < from + span && i < HMAX; i++) n += qHist[i];
    return n;
  endfunction

  task automatic expectPulse(string tag, int t0, int expWidth);
    int r = riseAt(t0, 60);
    check({tag, " latency"}, (r < 0) ? -1 : r - t0, LAT);
    check({tag, " width"}, widthAt(r), expWidth);
  endtask

  task automatic test_reset();
    step(3);
    check("R10 reset q", (q === 1'b0) ? 0 : 1, 0);
    check("R10 reset qN", (qN === 1'b1) ? 1 : 0, 1);
    rstN = 1'b1;
    step(4);
  endtask

  task automatic test_pos();
    int t0;
    pulseLen = 8'd5;
    t0 = edgeCnt; trigPos = 1'b1; step(4); trigPos = 1'b0; step(30);
    expectPulse("R1 pos rise", t0, 5);
  endtask

  task automatic test_neg();
    int t0;
    trigNeg = 1'b1; step(10);
    t0 = edgeCnt; trigPos = 1'b1; step(20);
    check("R3 pos rise with neg high", onesIn(t0, 20), 0);
    t0 = edgeCnt; trigNeg = 1'b0; step(25);
    expectPulse("R2 neg fall", t0, 5);
    trigPos = 1'b0; step(10);
    trigNeg = 1'b1; step(10);
    t0 = edgeCnt; trigNeg = 1'b0; step(20);
    check("R3 neg fall with pos low", onesIn(t0, 20), 0);
  endtask

  task automatic test_width();
    int t0;
    t0 = edgeCnt; trigPos = 1'b1; step(MW - 1); trigPos = 1'b0; step(20);
    check("R4 short high ignored", onesIn(t0, 20), 0);
    t0 = edgeCnt; trigPos = 1'b1; step(MW); trigPos = 1'b0; step(25);
    expectPulse("R4 exact width", t0, 5);
    trigPos = 1'b1; step(25);
    t0 = edgeCnt; trigPos = 1'b0; step(MW - 1); trigPos = 1'b1; step(20);
    check("R4 short low ignored", onesIn(t0, 20), 0);
    trigPos = 1'b0; step(10);
  endtask

  task automatic test_length();
    int t0;
    pulseLen = 8'd1;
    t0 = edgeCnt; trigPos = 1'b1; step(4); trigPos = 1'b0; step(20);
    expectPulse("R5 len one", t0, 1);
    pulseLen = 8'd0;
    t0 = edgeCnt; trigPos = 1'b1; step(4); trigPos = 1'b0; step(20);
    check("R5 len zero", onesIn(t0, 20), 0);
    pulseLen = 8'd8;
    t0 = edgeCnt; trigPos = 1'b1; step(4); trigPos = 1'b0; step(3);
    pulseLen = 8'd2; step(30);
    expectPulse("R5 len captured", t0, 8);
  endtask

  task automatic test_retrig();
    int t0;
    pulseLen = 8'd20;
    t0 = edgeCnt;
    trigPos = 1'b1; step(5); trigPos = 1'b0; step(5);
    trigPos = 1'b1; step(5); trigPos = 1'b0; step(50);
    expectPulse("R7 retrig at window", t0, 20);
    t0 = edgeCnt;
    trigPos = 1'b1; step(6); trigPos = 1'b0; step(5);
    trigPos = 1'b1; step(5); trigPos = 1'b0; step(60);
    expectPulse("R6 retrig after window", t0, 31);
  endtask

  task automatic test_clear();
    int t0;
    int tc;
    pulseLen = 8'd30;
    t0 = edgeCnt; trigPos = 1'b1; step(4); trigPos = 1'b0; step(6);
    check("R8 pulse running", qHist[t0 + LAT + 1] ? 1 : 0, 1);
    tc = edgeCnt; clearN = 1'b0; step(1);
    check("R8 clear drop", qHist[tc + 1] ? 1 : 0, 0);
    trigPos = 1'b1; step(4); trigPos = 1'b0; step(4);
    trigNeg = 1'b1; step(4); trigPos = 1'b1; step(4);
    trigNeg = 1'b0; step(4); trigPos = 1'b0; step(8);
    check("R8 held low during clear", onesIn(tc + 1, edgeCnt - tc), 0);
    t0 = edgeCnt; clearN = 1'b1; step(20);
    check("R8 no resume", onesIn(t0, 20), 0);
  endtask

  task automatic test_release();
    int t0;
    pulseLen = 8'd5;
    clearN = 1'b0; step(5);
    t0 = edgeCnt; trigPos = 1'b1; step(SS + MW);
    clearN = 1'b1; step(3); trigPos = 1'b0; step(25);
    check("R9 edge at release ignored", onesIn(t0, 30), 0);
    clearN = 1'b0; step(5);
    t0 = edgeCnt; trigPos = 1'b1; step(SS + MW - 1);
    clearN = 1'b1; step(3); trigPos = 1'b0; step(25);
    expectPulse("R9 edge after release", t0, 5);
  endtask

  initial begin
    #(8 * 100000);
    vectors++;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    test_reset();
    test_pos();
    test_neg();
    test_width();
    test_length();
    test_retrig();
    test_clear();
    test_release();
    check("R10 qN complement", compBad, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule